// File: doc/BRIEF.md
# Companion-Chip Control Register and GPIO Port

This block is a bus slave for a companion chip. It holds a set of 16-bit control registers, a read-only status word and a 16-line general purpose I/O port. A host reaches it over a simple register bus. The bus has a 32-bit address, a write strobe, a read strobe, write data that is truncated to 16 bits and a 16-bit registered read return.

Each GPIO line has a direction bit. The port drives `gpio_out` with the level register gated by direction. That output is recomputed only when software writes the direction register or the level register. Level writes are gated by direction before they are stored.

Sixteen input pins also feed the level register. After a two-flop synchronizer, a change on a pin sets or clears its level bit whatever the direction is. A pin change does not refresh the output. Interrupt request, mask and status words are plain storage only.

Top module: `ctrl_gpio_regblk`

## Requirements
- R1: Only address bits [5:0] select a register, so any upper address bits are ignored. The word offsets are: 0x00 mode, 0x04 clock divider, 0x08 status, 0x0C power, 0x10 clock control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level (write port), 0x28 level (read port).
- R2: Only the low 16 bits of a write are stored; bits [31:16] of the write data are dropped.
- R3: The mode, clock divider, clock control and three interrupt words store what is written and read it back. They reset to 0. Read data appears on `bus_rdata` one clock after the cycle with `bus_rd` high, and holds between reads.
- R4: A write to the power word stores the value. When bit 7 of the value is 1, bits 15 and 6 are also set, i.e. the stored word is value OR 0x8040.
- R5: The status word always reads 0x0002, and a write to its offset changes nothing.
- R6: A write at offset 0x24 or 0x28 stores (value AND direction) in the level register. A read at either offset returns the level register, and a read at 0x20 returns the direction register.
- R7: `gpio_out` resets to 0. It equals level AND direction as computed on the last direction write or level write, and it changes at no other time.
- R8: A change on any `gpio_in` pin sets or clears the matching level bit three clock edges later, whatever that bit's direction is. It leaves `gpio_out` untouched.
- R9: A read at an undecoded offset returns 0. This includes the unused word offsets and non-word-aligned offsets. A write to an undecoded offset alters no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Register address; only [5:0] decoded |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, truncated to 16 bits |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 16 | Asynchronous input pins |
| gpio_out | output | 16 | Output lines, level AND direction |

## Verification
The assertions assume the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume the address and write data are stable while a strobe is high. The bench drives one bus access at a time, on the falling edge, and drops the strobe before starting the next access. Pin changes on `gpio_in` are made only while no level write is in flight, and the bench waits several cycles so that the synchronizer has settled before the level is read back.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned DEC_W  = 6;
    localparam int unsigned NSEL   = 11;

    typedef logic [REG_W-1:0] word_t;
    typedef logic [DEC_W-1:0] off_t;

    // select indices
    localparam int unsigned S_MODE  = 0;
    localparam int unsigned S_CDIV  = 1;
    localparam int unsigned S_STAT  = 2;
    localparam int unsigned S_PWR   = 3;
    localparam int unsigned S_CCTL  = 4;
    localparam int unsigned S_IREQ  = 5;
    localparam int unsigned S_IMSK  = 6;
    localparam int unsigned S_ISTS  = 7;
    localparam int unsigned S_DIR   = 8;
    localparam int unsigned S_LVLW  = 9;
    localparam int unsigned S_LVLR  = 10;

    localparam word_t       STATUS_VAL   = 16'h0002;
    localparam word_t       PWR_FORCE    = 16'h8040;
    localparam int unsigned PWR_TRIG_BIT = 7;

    // offset of each select index: word offsets, four apart
    function automatic off_t sel_offset(input int unsigned idx);
        return off_t'(idx * 4);
    endfunction

    typedef struct packed {
        word_t mode;
        word_t cdiv;
        word_t pwr;
        word_t cctl;
        word_t ireq;
        word_t imsk;
        word_t ists;
        word_t dir;
        word_t level;
        word_t out;
        word_t rdata;
    } regs_t;

endpackage

// File: rtl/cgr_sync.sv
module cgr_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] chg_o
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] prev_q;

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= '0;
            end
            prev_q <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= stg_d[k];
            end
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
    assign chg_o  = stg_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/cgr_decode.sv
module cgr_decode
    import cgr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NSEL-1:0]   sel_o
);

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel_o[i] = (addr_i[DEC_W-1:0] == sel_offset(i));
    end

endmodule

// File: rtl/cgr_regfile.sv
module cgr_regfile
    import cgr_pkg::*;
#(
    parameter int unsigned WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [NSEL-1:0]    sel_i,
    input  logic [WDATA_W-1:0] wdata_i,
    input  word_t              pin_val_i,
    input  word_t              pin_chg_i,
    output word_t              rdata_o,
    output word_t              out_o,
    output word_t              dir_o,
    output word_t              level_o,
    output word_t              pwr_o
);

    regs_t r_q, r_d;
    word_t wv;
    word_t rd_mux;

    assign wv = wdata_i[REG_W-1:0];

    always_comb begin
        rd_mux = '0;
        if (sel_i[S_MODE])                       rd_mux = r_q.mode;
        else if (sel_i[S_CDIV])                  rd_mux = r_q.cdiv;
        else if (sel_i[S_STAT])                  rd_mux = STATUS_VAL;
        else if (sel_i[S_PWR])                   rd_mux = r_q.pwr;
        else if (sel_i[S_CCTL])                  rd_mux = r_q.cctl;
        else if (sel_i[S_IREQ])                  rd_mux = r_q.ireq;
        else if (sel_i[S_IMSK])                  rd_mux = r_q.imsk;
        else if (sel_i[S_ISTS])                  rd_mux = r_q.ists;
        else if (sel_i[S_DIR])                   rd_mux = r_q.dir;
        else if (sel_i[S_LVLW] || sel_i[S_LVLR]) rd_mux = r_q.level;
    end

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (sel_i[S_MODE]) r_d.mode = wv;
            if (sel_i[S_CDIV]) r_d.cdiv = wv;
            if (sel_i[S_PWR])  r_d.pwr  = wv[PWR_TRIG_BIT] ? (wv | PWR_FORCE) : wv;
            if (sel_i[S_CCTL]) r_d.cctl = wv;
            if (sel_i[S_IREQ]) r_d.ireq = wv;
            if (sel_i[S_IMSK]) r_d.imsk = wv;
            if (sel_i[S_ISTS]) r_d.ists = wv;
            if (sel_i[S_DIR]) begin
                r_d.dir = wv;
                r_d.out = r_q.level & wv;
            end
            if (sel_i[S_LVLW] || sel_i[S_LVLR]) begin
                r_d.level = wv & r_q.dir;
                r_d.out   = wv & r_q.dir;
            end
        end
        // pin changes update level only; output is not re-evaluated
        r_d.level = (r_d.level & ~pin_chg_i) | (pin_val_i & pin_chg_i);
        if (rd_i) begin
            r_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata_o = r_q.rdata;
    assign out_o   = r_q.out;
    assign dir_o   = r_q.dir;
    assign level_o = r_q.level;
    assign pwr_o   = r_q.pwr;

endmodule

// File: rtl/ctrl_gpio_regblk.sv
module ctrl_gpio_regblk
    import cgr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned WDATA_W     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [WDATA_W-1:0] bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [REG_W-1:0]   gpio_in,
    output logic [REG_W-1:0]   gpio_out
);

    logic [NSEL-1:0] sel_w;
    word_t           pin_val_w;
    word_t           pin_chg_w;
    word_t           dir_w;
    word_t           level_w;
    word_t           pwr_w;

    cgr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (sel_w)
    );

    cgr_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (gpio_in),
        .sync_o (pin_val_w),
        .chg_o  (pin_chg_w)
    );

    cgr_regfile #(.WDATA_W(WDATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .sel_i     (sel_w),
        .wdata_i   (bus_wdata),
        .pin_val_i (pin_val_w),
        .pin_chg_i (pin_chg_w),
        .rdata_o   (bus_rdata),
        .out_o     (gpio_out),
        .dir_o     (dir_w),
        .level_o   (level_w),
        .pwr_o     (pwr_w)
    );

endmodule

// File: rtl/cgr_checker.sv
module cgr_checker
    import cgr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned WDATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [WDATA_W-1:0] bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic [REG_W-1:0]   gpio_out,
    input logic [REG_W-1:0]   dir,
    input logic [REG_W-1:0]   level,
    input logic [REG_W-1:0]   pwr
);

    off_t a6;
    logic known;
    assign a6 = bus_addr[DEC_W-1:0];

    always_comb begin
        known = 1'b0;
        for (int i = 0; i < NSEL; i++) begin
            if (a6 == sel_offset(i)) known = 1'b1;
        end
    end

    // R4
    a_r4_power_force: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a6 == 6'h0C && bus_wdata[PWR_TRIG_BIT]) |=> (pwr[15] && pwr[6]));

    // R5
    a_r5_status_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && a6 == 6'h08) |=> (bus_rdata == STATUS_VAL));

    // R6
    a_r6_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (a6 == 6'h24 || a6 == 6'h28))
        |=> (gpio_out == ($past(bus_wdata[REG_W-1:0]) & $past(dir))));

    // R7
    a_r7_dir_reeval: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a6 == 6'h20)
        |=> (gpio_out == ($past(level) & $past(bus_wdata[REG_W-1:0]))));

    // R7
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(gpio_out));

    // R7
    a_r7_out_within_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out & ~dir) == '0);

    // R9
    a_r9_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !known) |=> (bus_rdata == '0));

endmodule

bind ctrl_gpio_regblk cgr_checker #(.ADDR_W(ADDR_W), .WDATA_W(WDATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_out  (gpio_out),
    .dir       (dir_w),
    .level     (level_w),
    .pwr       (pwr_w)
);

// File: tb/test_ctrl_gpio_regblk.sv
`timescale 1ns/1ps
module test_ctrl_gpio_regblk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];
    logic rd_flag = 1'b0;

    always #10 clk = ~clk;

    ctrl_gpio_regblk i_ctrl_gpio_regblk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out)
    );

    // monitor: a read captured on a rising edge is compared at the next falling edge
    always @(posedge clk) rd_flag <= bus_rd;

    always @(negedge clk) begin
        if (rd_flag) begin
            item_t it;
            checks++;
            if (sbq.size() == 0) begin
                failures++;
                $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
            end else begin
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [15:0] e, input string t);
        item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.exp = e; it.tag = t;
        sbq.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_out(input logic [15:0] e, input string t);
        checks++;
        if (gpio_out !== e) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", t, gpio_out, e);
        end
    endtask

    task automatic pins(input logic [15:0] v);
        @(negedge clk);
        gpio_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk_out(16'h0000, "R7 reset output low");
        rd(32'h00, 16'h0000, "R3 mode reset");
        rd(32'h08, 16'h0002, "R5 status reset");
        rd(32'h24, 16'h0000, "R6 level reset");

        wr(32'h00, 32'hABCD_1234);
        rd(32'h00, 16'h1234, "R2 truncation");
        wr(32'h04, 32'h0000_5A5A);
        wr(32'h10, 32'h0000_00FF);
        wr(32'h14, 32'h0000_0101);
        wr(32'h18, 32'h0000_8001);
        wr(32'h1C, 32'hFFFF_7777);
        rd(32'h04, 16'h5A5A, "R3 divider");
        rd(32'h10, 16'h00FF, "R3 clock control");
        rd(32'h14, 16'h0101, "R3 irq request");
        rd(32'h18, 16'h8001, "R3 irq mask");
        rd(32'h1C, 16'h7777, "R3 irq status");
        rd(32'h1000_0004, 16'h5A5A, "R1 upper address ignored");
        rd(32'hFFFF_FFD0, 16'h00FF, "R1 alias of 0x10");

        wr(32'h0C, 32'h0080);
        rd(32'h0C, 16'h80C0, "R4 force on bit7");
        wr(32'h0C, 32'h0001);
        rd(32'h0C, 16'h0001, "R4 no force");
        wr(32'h0C, 32'h7F7F);
        rd(32'h0C, 16'h7F7F, "R4 bit7 clear");
        wr(32'h0C, 32'h0081);
        rd(32'h0C, 16'h80C1, "R4 force merge");

        wr(32'h08, 32'hFFFF);
        rd(32'h08, 16'h0002, "R5 status write ignored");

        wr(32'h20, 32'h00FF);
        rd(32'h20, 16'h00FF, "R6 direction readback");
        chk_out(16'h0000, "R7 dir write with level 0");
        wr(32'h24, 32'hFFFF);
        chk_out(16'h00FF, "R7 level write output");
        rd(32'h28, 16'h00FF, "R6 masked level at read port");
        rd(32'h24, 16'h00FF, "R6 masked level at write port");
        wr(32'h28, 32'h0F0F);
        chk_out(16'h000F, "R6 write via read port");
        rd(32'h24, 16'h000F, "R6 alias level");
        wr(32'h20, 32'hFFFF);
        chk_out(16'h000F, "R7 dir widen");

        pins(16'h1000);
        rd(32'h28, 16'h100F, "R8 pin sets level");
        chk_out(16'h000F, "R8 no output re-eval");
        wr(32'h20, 32'hFFFF);
        chk_out(16'h100F, "R7 dir write picks up pin");
        pins(16'h1001);
        pins(16'h1000);
        rd(32'h28, 16'h100E, "R8 pin clears level");
        wr(32'h20, 32'h00F0);
        chk_out(16'h0000, "R7 dir narrow");
        pins(16'h3000);
        rd(32'h28, 16'h300E, "R8 pin on input-direction line");
        chk_out(16'h0000, "R8 output unchanged");

        wr(32'h2C, 32'h1234);
        wr(32'h30, 32'hFFFF);
        wr(32'h3C, 32'hFFFF);
        wr(32'h02, 32'hFFFF);
        chk_out(16'h0000, "R9 undecoded write output");
        rd(32'h2C, 16'h0000, "R9 undecoded 0x2C");
        rd(32'h02, 16'h0000, "R9 unaligned 0x02");
        rd(32'h3C, 16'h0000, "R9 undecoded 0x3C");
        rd(32'h00, 16'h1234, "R9 mode untouched");
        rd(32'h28, 16'h300E, "R9 level untouched");
        rd(32'h20, 16'h00F0, "R9 direction untouched");
        rd(32'h0C, 16'h80C1, "R9 power untouched");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        finish_run();
    end

endmodule